// File: doc/BRIEF.md
# Extended 64-Colour Palette Unit

This unit gives an 8x8-cell attribute display a programmable palette of 64 colours. The CPU reaches it through two I/O ports. One is a write-only selector port: its top two bits pick an access group and its low six bits pick a palette entry. The other is a read/write data port, whose meaning follows the group that is currently selected. In the palette group the data port reads and writes the selected entry. In the mode group it holds a single enable bit. In the two remaining groups it is inert.

On the video side, each pixel request carries four items: an ink/paper flag, a 3-bit colour number, and the flash and bright attribute bits. The unit answers with an 8-bit colour byte laid out as GGGRRRBB. When the palette is enabled, the flash and bright bits select one of four 16-entry banks. Ink colours sit in the lower eight entries of that bank and paper colours in the upper eight. When the palette is disabled, a fixed 16-colour classic table drives the output instead.

Top module: `ulp_palette_unit`

## Requirements
- R1: After a synchronous reset the unit is in the following state. The selector holds 0 (group 00, entry 0) and the mode bit is 0, so the classic table is in use. Every palette entry holds 0x00, and `pix_rgb` reads 0x00.
- R2: The selector port is decoded on the full address 0xBF3B. A write there stores the whole byte. The port is write-only: a read at 0xBF3B returns 0xFF.
- R3: With selector bits [7:6] = 00, a write to the data port at 0xFF3B stores the byte into entry selector[5:0]. A read of the data port returns that entry in the same cycle, on a combinational path.
- R4: With selector bits [7:6] = 01, a data-port write sets the mode bit from D0 and ignores D7:D1. A data-port read returns {7'b0, mode}. No palette entry changes.
- R5: With selector bits [7:6] = 10 or 11, data-port writes have no effect, and data-port reads return 0xFF.
- R6: With mode = 1, `pix_rgb` at the clock edge after a request equals entry {flash, bright, paper, colour[2:0]}. That index is bank*16 + paper*8 + colour.
- R7: With mode = 0, `pix_rgb` at the clock edge after a request takes the classic colour. Colour bit 2 drives green, bit 1 drives red and bit 0 drives blue. An active channel has level 5/5/2 (G/R/B) when bright = 0 and level 7/7/3 when bright = 1. Flash and paper have no effect.
- R8: Writes to any other address leave the selector, the mode and the palette unchanged. `io_rdata` is 0xFF whenever no port read is in progress.
- R9: A palette write and a lookup of the same entry in the same cycle return the old value. The new value appears on the next request.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | CPU I/O address |
| io_wr | input | 1 | CPU I/O write strobe, one cycle per write |
| io_rd | input | 1 | CPU I/O read strobe |
| io_wdata | input | 8 | CPU write data |
| io_rdata | output | 8 | CPU read data, combinational |
| pix_paper | input | 1 | 1 = paper pixel, 0 = ink pixel |
| pix_colour | input | 3 | Attribute colour number |
| pix_flash | input | 1 | Flash attribute bit (high bank bit) |
| pix_bright | input | 1 | Bright attribute bit (low bank bit) |
| pix_rgb | output | 8 | Colour byte GGGRRRBB, registered |

## Verification
The port writes take effect at the clock edge inside the write strobe. The bench therefore drives each write between two falling edges and reads back only after the following falling edge. Data-port reads are combinational, so they are sampled one time unit after the read strobe is raised, in the same cycle. `pix_rgb` passes through exactly one register: the bench presents a request at a falling edge and samples at the next falling edge. The same-cycle write-and-lookup case is sampled on that edge and again one request later, to see the old value and then the new one.

// File: rtl/ulp_palette_pkg.sv
package ulp_palette_pkg;

    localparam int COL_W   = 8;
    localparam int BANKS   = 4;
    localparam int PER_BNK = 16;
    localparam int ENTRIES = BANKS * PER_BNK;
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef logic [COL_W-1:0] colour_t;
    typedef logic [IDX_W-1:0] pal_idx_t;

    typedef enum logic [1:0] {
        GRP_PALETTE = 2'b00,
        GRP_MODE    = 2'b01,
        GRP_RSVD_A  = 2'b10,
        GRP_RSVD_B  = 2'b11
    } grp_e;

    typedef struct packed {
        logic       paper;
        logic [2:0] colour;
        logic       flash;
        logic       bright;
    } pix_req_t;

    // bank = {flash,bright}; ink entries low half, paper entries high half
    function automatic pal_idx_t pal_index(input pix_req_t r);
        return {r.flash, r.bright, r.paper, r.colour};
    endfunction

    // fixed 16-colour table, GGGRRRBB
    function automatic colour_t classic_rgb(input logic bright, input logic [2:0] c);
        logic [2:0] lvl3;
        logic [1:0] lvl2;
        lvl3 = bright ? 3'd7 : 3'd5;
        lvl2 = bright ? 2'd3 : 2'd2;
        return {(c[2] ? lvl3 : 3'd0), (c[1] ? lvl3 : 3'd0), (c[0] ? lvl2 : 2'd0)};
    endfunction

endpackage

// File: rtl/ulp_port_decode.sv
module ulp_port_decode
    import ulp_palette_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] SEL_PORT  = 16'hBF3B,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'hFF3B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  colour_t           io_wdata,
    input  colour_t           entry_rdata,
    output colour_t           io_rdata,
    output logic              pal_we,
    output pal_idx_t          pal_addr,
    output colour_t           pal_wdata,
    output colour_t           sel_q,
    output logic              mode_q
);
    logic hit_sel, hit_data;
    grp_e grp;

    assign hit_sel  = (io_addr == SEL_PORT);
    assign hit_data = (io_addr == DATA_PORT);
    assign grp      = grp_e'(sel_q[7:6]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            if (io_wr && hit_sel)
                sel_q <= io_wdata;
            if (io_wr && hit_data && grp == GRP_MODE)
                mode_q <= io_wdata[0];
        end
    end

    assign pal_we    = io_wr && hit_data && (grp == GRP_PALETTE);
    assign pal_addr  = sel_q[IDX_W-1:0];
    assign pal_wdata = io_wdata;

    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && hit_data) begin
            unique case (grp)
                GRP_PALETTE: io_rdata = entry_rdata;
                GRP_MODE:    io_rdata = {7'b0, mode_q};
                default:     io_rdata = 8'hFF;
            endcase
        end
    end
endmodule

// File: rtl/ulp_palette_ram.sv
module ulp_palette_ram
    import ulp_palette_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  pal_idx_t cpu_addr,
    input  colour_t  wdata,
    output colour_t  cpu_rdata,
    input  pal_idx_t vid_addr,
    output colour_t  vid_rdata
);
    colour_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[cpu_addr] <= wdata;
        end
    end

    assign cpu_rdata = mem[cpu_addr];
    assign vid_rdata = mem[vid_addr];
endmodule

// File: rtl/ulp_lookup.sv
module ulp_lookup
    import ulp_palette_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mode,
    input  pix_req_t req,
    input  colour_t  pal_rdata,
    output colour_t  rgb
);
    colour_t next_rgb;

    assign next_rgb = mode ? pal_rdata : classic_rgb(req.bright, req.colour);

    always_ff @(posedge clk) begin
        if (rst) rgb <= '0;
        else     rgb <= next_rgb;
    end
endmodule

// File: rtl/ulp_palette_unit.sv
module ulp_palette_unit
    import ulp_palette_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] SEL_PORT  = 16'hBF3B,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'hFF3B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              pix_paper,
    input  logic [2:0]        pix_colour,
    input  logic              pix_flash,
    input  logic              pix_bright,
    output logic [7:0]        pix_rgb
);
    colour_t  sel_q, entry_rdata, vid_rdata, pal_wdata;
    logic     mode_q, pal_we;
    pal_idx_t pal_addr;
    pix_req_t req;

    assign req = '{paper: pix_paper, colour: pix_colour,
                   flash: pix_flash, bright: pix_bright};

    ulp_port_decode #(
        .ADDR_W(ADDR_W), .SEL_PORT(SEL_PORT), .DATA_PORT(DATA_PORT)
    ) u_dec (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .entry_rdata(entry_rdata), .io_rdata(io_rdata),
        .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
        .sel_q(sel_q), .mode_q(mode_q)
    );

    ulp_palette_ram u_ram (
        .clk(clk), .rst(rst), .we(pal_we), .cpu_addr(pal_addr),
        .wdata(pal_wdata), .cpu_rdata(entry_rdata),
        .vid_addr(pal_index(req)), .vid_rdata(vid_rdata)
    );

    ulp_lookup u_lut (
        .clk(clk), .rst(rst), .mode(mode_q), .req(req),
        .pal_rdata(vid_rdata), .rgb(pix_rgb)
    );
endmodule

// File: rtl/ulp_palette_chk.sv
module ulp_palette_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] SEL_PORT  = 16'hBF3B,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'hFF3B
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic [2:0]        pix_colour,
    input logic [7:0]        pix_rgb,
    input logic [7:0]        sel_q,
    input logic              mode_q
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sel_q == 8'h00 && !mode_q && pix_rgb == 8'h00));

    a_r2_sel_write: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == SEL_PORT) |=> sel_q == $past(io_wdata));

    a_r8_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr == SEL_PORT) |=> $stable(sel_q));

    a_r4_mode_write: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == DATA_PORT && sel_q[7:6] == 2'b01)
        |=> mode_q == $past(io_wdata[0]));

    a_r5_hidden_read: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == DATA_PORT && sel_q[7]) |-> io_rdata == 8'hFF);

    a_r7_classic_black: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && pix_colour == 3'd0) |=> pix_rgb == 8'h00);
endmodule

bind ulp_palette_unit ulp_palette_chk #(
    .ADDR_W(ADDR_W), .SEL_PORT(SEL_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pix_colour(pix_colour),
    .pix_rgb(pix_rgb), .sel_q(sel_q), .mode_q(mode_q)
);

// File: tb/ulp_palette_unit_test.sv
`timescale 1ns/1ps
module ulp_palette_unit_test;
    localparam logic [15:0] SEL  = 16'hBF3B;
    localparam logic [15:0] DATA = 16'hFF3B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        pix_paper = 1'b0, pix_flash = 1'b0, pix_bright = 1'b0;
    logic [2:0]  pix_colour = '0;
    logic [7:0]  pix_rgb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ulp_palette_unit uut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .pix_paper(pix_paper),
        .pix_colour(pix_colour), .pix_flash(pix_flash), .pix_bright(pix_bright),
        .pix_rgb(pix_rgb)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic pixel(input logic p, input logic [2:0] c, input logic f,
                         input logic b, output logic [7:0] d);
        @(negedge clk);
        pix_paper = p; pix_colour = c; pix_flash = f; pix_bright = b;
        @(negedge clk);
        d = pix_rgb;
    endtask

    function automatic logic [7:0] pattern(input int i);
        return 8'(i * 37 + 5);
    endfunction

    function automatic logic [7:0] classic_exp(input logic b, input logic [2:0] c);
        logic [7:0] v = 8'h00;
        if (c[2]) v[7:5] = b ? 3'b111 : 3'b101;
        if (c[1]) v[4:2] = b ? 3'b111 : 3'b101;
        if (c[0]) v[1:0] = b ? 2'b11 : 2'b10;
        return v;
    endfunction

    task automatic t_reset;
        logic [7:0] d;
        check("R1 rgb after reset", pix_rgb, 8'h00);
        io_read(DATA, d);
        check("R1 entry0 after reset", d, 8'h00);
        io_write(SEL, 8'h3F);
        io_read(DATA, d);
        check("R1 entry63 after reset", d, 8'h00);
        io_write(SEL, 8'h40);
        io_read(DATA, d);
        check("R1 mode after reset", d, 8'h00);
    endtask

    task automatic t_select_port;
        logic [7:0] d;
        io_read(SEL, d);
        check("R2 select port write-only", d, 8'hFF);
        io_write(SEL, 8'h05);
        io_write(DATA, 8'hA5);
        io_write(SEL, 8'h06);
        io_read(DATA, d);
        check("R2 select moved to entry 6", d, 8'h00);
        io_write(SEL, 8'h05);
        io_read(DATA, d);
        check("R2 select back on entry 5", d, 8'hA5);
    endtask

    task automatic t_palette_rw;
        logic [7:0] d;
        for (int i = 0; i < 64; i++) begin
            io_write(SEL, 8'(i));
            io_write(DATA, pattern(i));
        end
        for (int i = 0; i < 64; i++) begin
            io_write(SEL, 8'(i));
            io_read(DATA, d);
            check($sformatf("R3 readback entry %0d", i), d, pattern(i));
        end
    endtask

    task automatic t_mode_group;
        logic [7:0] d;
        io_write(SEL, 8'h40 | 8'h07);
        io_write(DATA, 8'hFE);
        io_read(DATA, d);
        check("R4 D0=0 keeps mode off", d, 8'h00);
        io_write(DATA, 8'h01);
        io_read(DATA, d);
        check("R4 mode on", d, 8'h01);
        io_write(SEL, 8'h07);
        io_read(DATA, d);
        check("R4 palette untouched by mode write", d, pattern(7));
    endtask

    task automatic t_hidden;
        logic [7:0] d;
        for (int g = 2; g < 4; g++) begin
            io_write(SEL, 8'(g << 6) | 8'h09);
            io_write(DATA, 8'h00);
            io_read(DATA, d);
            check($sformatf("R5 hidden read group %0d", g), d, 8'hFF);
        end
        io_write(SEL, 8'h09);
        io_read(DATA, d);
        check("R5 entry 9 survives hidden writes", d, pattern(9));
        io_write(SEL, 8'h40);
        io_read(DATA, d);
        check("R5 mode survives hidden writes", d, 8'h01);
    endtask

    task automatic t_lookup;
        logic [7:0] d;
        for (int i = 0; i < 64; i++) begin
            pixel(i[3], i[2:0], i[5], i[4], d);
            check($sformatf("R6 lookup index %0d", i), d, pattern(i));
        end
    endtask

    task automatic t_other_addr;
        logic [7:0] d;
        io_write(SEL, 8'h0A);
        io_write(16'hFF3C, 8'h11);
        io_write(16'h3F3B, 8'h22);
        io_write(16'hBF3A, 8'h4B);
        io_read(DATA, d);
        check("R8 entry 10 and selector untouched", d, pattern(10));
        @(negedge clk);
        io_addr = DATA;
        #1 check("R8 rdata idle", io_rdata, 8'hFF);
    endtask

    task automatic t_same_cycle;
        logic [7:0] d;
        io_write(SEL, 8'h2C);
        @(negedge clk);
        io_addr = DATA; io_wdata = 8'h5A; io_wr = 1'b1;
        pix_flash = 1'b1; pix_bright = 1'b0; pix_paper = 1'b1; pix_colour = 3'd4;
        @(negedge clk);
        io_wr = 1'b0;
        check("R9 same-cycle lookup sees old", pix_rgb, pattern(44));
        @(negedge clk);
        check("R9 next lookup sees new", pix_rgb, 8'h5A);
    endtask

    task automatic t_classic;
        logic [7:0] d;
        io_write(SEL, 8'h40);
        io_write(DATA, 8'hFE);
        for (int i = 0; i < 16; i++) begin
            pixel(i[0], i[2:0], ~i[0], i[3], d);
            check($sformatf("R7 classic bright=%0d colour=%0d", i[3], i[2:0]),
                  d, classic_exp(i[3], i[2:0]));
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_select_port();
        t_palette_rw();
        t_mode_group();
        t_hidden();
        t_lookup();
        t_other_addr();
        t_same_cycle();
        t_classic();
        finish_run();
    end
endmodule